// File: doc/BRIEF.md
# Burst Address Generator with Selectable Stepping Order

This block supplies the word address to a synchronous burst memory. A base address is captured on a rising clock edge whenever either of two active-low load strobes is low: one strobe serves a processor, the other a memory controller. After the load, the block can step through a four-beat burst by itself. Each cycle in which the active-low advance input is low moves the burst one beat forward. Only the two least-significant address bits change during a burst. The upper bits keep the value that was loaded.

A static order input picks how the two low bits move. When it is low, the order is linear: the field counts up by one and wraps modulo four. When it is high, the order is interleaved: the field is the starting value XORed with a beat count that runs 0, 1, 2, 3. Using bursts is optional. A new external address can be loaded on every cycle without a lost cycle. If a strobe and advance are both active in the same cycle, the load takes priority.

Top module: `burst_addr_gen`

## Requirements
- R1: When the synchronous reset is high at a rising edge, the output address becomes all zeros on the next cycle.
- R2: When the processor strobe is low at a rising edge, the output address equals the sampled input address from the next cycle on.
- R3: When the controller strobe is low at a rising edge, the output address equals the sampled input address from the next cycle on. Having both strobes low also loads the address.
- R4: With the order input low (linear), each edge with advance low and both strobes high changes the low 2-bit field from s+k to s+k+1 modulo 4, where s is the loaded field and k is the beat count.
- R5: With the order input high (interleaved), the low 2-bit field after k advances equals s XOR k, where k runs 0, 1, 2, 3 and then wraps.
- R6: An edge with advance high and both strobes high leaves the output address unchanged.
- R7: When a strobe and advance are both low at the same edge, the load wins. The output equals the input address with the beat count at zero.
- R8: Four advances after a load bring the low field back to its starting value. The bits above the low two bits never change during a burst, including when the linear field wraps from 3 to 0.
- R9: Loads on consecutive cycles each take effect in the cycle that follows, with no lost cycle. A load in the middle of a burst restarts the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | ADDR_W | External address sampled on a load |
| strobeCpuN | input | 1 | Processor load strobe, active low |
| strobeCtlN | input | 1 | Controller load strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| orderSel | input | 1 | Stepping order: low = linear, high = interleaved |
| addrOut | output | ADDR_W | Current internal word address |

## Verification
The bench builds the block with ADDR_W set to 12 and BURST_W left at 2. This keeps the four-beat burst field while making the upper-bit patterns short enough to write as readable hex vectors. With a 12-bit address, the table can use upper fields with many bits set to show that a linear wrap from 3 to 0 never carries into bit 2. A directed sweep then starts from each of the four low-field values in both orders and follows a full burst and its wrap.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic load;   // capture a new base address
    logic step;   // move the burst one beat forward
  } ctlStrobes_t;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strobeCpuN,
  input  logic               strobeCtlN,
  input  logic               advanceN,
  output ctlStrobes_t        strobes,
  output logic [BURST_W-1:0] beat
);

  logic [BURST_W-1:0] beatQ;

  // A load from either source takes priority over an advance
  always_comb begin
    strobes.load = !strobeCpuN || !strobeCtlN;
    strobes.step = !advanceN && strobeCpuN && strobeCtlN;
  end

  always_ff @(posedge clk) begin
    if (rst)               beatQ <= '0;
    else if (strobes.load) beatQ <= '0;
    else if (strobes.step) beatQ <= beatQ + 1'b1;
  end

  assign beat = beatQ;

  // R7 / R9: a load restarts the beat count
  a_r7_load_clears_beat: assert property (@(posedge clk) disable iff (rst)
    (!strobeCpuN || !strobeCtlN) |=> (beat == '0));

  // R4: an advance without a load moves the beat by one
  a_r4_step_increments: assert property (@(posedge clk) disable iff (rst)
    (strobeCpuN && strobeCtlN && !advanceN) |=> (beat == $past(beat) + 1'b1));

  // R6: idle leaves the beat count alone
  a_r6_idle_holds_beat: assert property (@(posedge clk) disable iff (rst)
    (strobeCpuN && strobeCtlN && advanceN) |=> $stable(beat));

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addrIn,
  input  ctlStrobes_t        strobes,
  input  logic [BURST_W-1:0] beat,
  input  logic               orderSel,
  output logic [ADDR_W-1:0]  addrOut
);

  localparam int UPPER_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  baseQ;
  logic [BURST_W-1:0] startField;
  logic [BURST_W-1:0] linField;
  logic [BURST_W-1:0] ilvField;
  logic [BURST_W-1:0] burstField;

  always_ff @(posedge clk) begin
    if (rst)               baseQ <= '0;
    else if (strobes.load) baseQ <= addrIn;
  end

  assign startField = baseQ[BURST_W-1:0];

  // Linear: modular add within the burst field only
  assign linField = startField + beat;

  // Interleaved: per-bit exclusive-or with the beat count
  for (genvar b = 0; b < BURST_W; b++) begin : g_ilv
    assign ilvField[b] = startField[b] ^ beat[b];
  end

  assign burstField = orderSel ? ilvField : linField;
  assign addrOut    = {baseQ[ADDR_W-1:BURST_W], burstField};

  // R2 / R3: a load is visible at the output on the next cycle
  a_r2_load_visible: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (baseQ == $past(addrIn)));

  // R8: upper bits change only on a load
  a_r8_upper_stable: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> (addrOut[ADDR_W-1:BURST_W] == $past(addrOut[ADDR_W-1:BURST_W])));

  // R6: base is held without a load
  a_r6_base_holds: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> $stable(baseQ));

  initial begin
    a_upper_width: assert (UPPER_W >= 1);
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              strobeCpuN,
  input  logic              strobeCtlN,
  input  logic              advanceN,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] addrOut
);

  ctlStrobes_t        strobes;
  logic [BURST_W-1:0] beat;

  burst_ctrl #(.BURST_W(BURST_W)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .strobeCpuN (strobeCpuN),
    .strobeCtlN (strobeCtlN),
    .advanceN   (advanceN),
    .strobes    (strobes),
    .beat       (beat)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .addrIn   (addrIn),
    .strobes  (strobes),
    .beat     (beat),
    .orderSel (orderSel),
    .addrOut  (addrOut)
  );

  // R1: reset forces a zero address
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (addrOut == '0));

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int ADDR_W = 12;
  localparam int NVEC   = 19;

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] addrIn;
  logic              strobeCpuN, strobeCtlN, advanceN, orderSel;
  logic [ADDR_W-1:0] addrOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  burst_addr_gen #(.ADDR_W(ADDR_W), .BURST_W(2)) i_burst_addr_gen (
    .clk(clk), .rst(rst), .addrIn(addrIn), .strobeCpuN(strobeCpuN),
    .strobeCtlN(strobeCtlN), .advanceN(advanceN), .orderSel(orderSel),
    .addrOut(addrOut)
  );

  // {rst, cpuN, ctlN, advN, order, addrIn[11:0], expected[11:0]}
  localparam logic [28:0] VEC [NVEC] = '{
    {5'b1_1_1_1_0, 12'h000, 12'h000},  // R1 reset
    {5'b0_0_1_1_0, 12'hA51, 12'hA51},  // R2 processor load
    {5'b0_1_1_0_0, 12'h000, 12'hA52},  // R4 linear
    {5'b0_1_1_0_0, 12'h000, 12'hA53},  // R4
    {5'b0_1_1_0_0, 12'h000, 12'hA50},  // R8 wrap, no carry
    {5'b0_1_1_0_0, 12'h000, 12'hA51},  // R8 back to start
    {5'b0_1_1_1_0, 12'hFFF, 12'hA51},  // R6 idle
    {5'b0_1_0_1_1, 12'h3F6, 12'h3F6},  // R3 controller load
    {5'b0_1_1_0_1, 12'h000, 12'h3F7},  // R5 10^01
    {5'b0_1_1_0_1, 12'h000, 12'h3F4},  // R5 10^10
    {5'b0_1_1_0_1, 12'h000, 12'h3F5},  // R5 10^11
    {5'b0_1_1_0_1, 12'h000, 12'h3F6},  // R8 interleaved wrap
    {5'b0_0_1_0_0, 12'h123, 12'h123},  // R7 load beats advance
    {5'b0_1_1_0_0, 12'h000, 12'h120},  // R8 3 -> 0 no carry
    {5'b0_1_0_0_0, 12'h800, 12'h800},  // R7 controller load with advance
    {5'b0_0_1_1_0, 12'h555, 12'h555},  // R9 back-to-back
    {5'b0_0_0_1_0, 12'h00F, 12'h00F},  // R3 both strobes
    {5'b0_1_1_0_0, 12'h000, 12'h00C},  // R4
    {5'b1_1_1_1_0, 12'h000, 12'h000}   // R1 reset mid-burst
  };

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    checks++;
    if (addrOut !== exp) begin
      errors++;
      $display("FAIL %s: addrOut=%h expected=%h", req, addrOut, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, check at the next falling edge
  task automatic cycle(input logic r, input logic pN, input logic cN,
                       input logic aN, input logic o, input logic [ADDR_W-1:0] a);
    rst = r; strobeCpuN = pN; strobeCtlN = cN; advanceN = aN; orderSel = o; addrIn = a;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; strobeCpuN = 1'b1; strobeCtlN = 1'b1; advanceN = 1'b1;
    orderSel = 1'b0; addrIn = '0;
    @(negedge clk);
    @(negedge clk);
    check("R1", '0);

    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i][28], VEC[i][27], VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23:12]);
      check($sformatf("vector %0d", i), VEC[i][11:0]);
    end

    // R4 / R5 / R8 sweep: every start value, both orders, full burst plus wrap
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        logic [ADDR_W-1:0] base;
        base = {10'h2B7, s[1:0]};
        cycle(1'b0, 1'b0, 1'b1, 1'b1, o[0], base);
        check("R2 sweep load", base);
        for (int k = 1; k <= 4; k++) begin
          logic [1:0] kk;
          logic [1:0] fld;
          kk  = k[1:0];
          fld = o[0] ? (s[1:0] ^ kk) : (s[1:0] + kk);
          cycle(1'b0, 1'b1, 1'b1, 1'b0, o[0], 12'hFFF);
          check(o[0] ? "R5 interleave sweep" : "R4 linear sweep", {10'h2B7, fld});
        end
      end
    end

    // R9: load mid-burst restarts the count
    cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h6C2);
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
    check("R4 mid", 12'h6C3);
    cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12'h6C2);
    check("R9 reload", 12'h6C2);
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
    check("R9 restarted beat", 12'h6C3);

    // R6: idle with a changing address input
    cycle(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 12'hABC);
    cycle(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 12'h123);
    check("R6 idle", 12'h6C3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule